// File: doc/BRIEF.md
# Mains-Synchronized Acquisition Trigger

This block decides when each of four capacitive-sensing acquisition types may begin. A type whose synchronization is enabled waits for a falling edge on an asynchronous, mains-derived input. This keeps its measurement at a fixed phase of the 50 Hz or 60 Hz interference. A type with synchronization disabled starts as soon as it is requested. Type 0 is the matrix-scan type. Starting it launches a sequence of X-line starts. A programmable interval counted in clock cycles spaces these starts apart, and a one-cycle pulse marks the end of the sequence.

Requests are single-cycle pulses, and each one is held until it is served. Only one type starts in any cycle. The scan interval, the line count and the enable bits are captured between scans, so a scan that is running always completes with the settings it started with.

Top module: `mains_sync_trigger`

## Requirements
- R1: syncPin passes through two synchronizing flops before edge detection. A pending type with synchronization enabled pulses typeStart on the third rising clock edge after syncPin falls. A rising edge of syncPin starts nothing.
- R2: With syncEn[i]=0, held stable for at least one cycle, and the block idle with no lower-index type eligible, typeStart[i] pulses in the second cycle after the cycle in which acqReq[i] is sampled high.
- R3: Each accepted request yields exactly one typeStart pulse. A request for a type that is already pending is dropped.
- R4: At most one typeStart bit is high in any cycle. Among eligible types, the lowest index wins, with index 0 as the matrix-scan type. The others wait for a later edge or cycle.
- R5: A type 0 start raises xStart with xIndex=0 in the same cycle as typeStart[0].
- R6: Within a scan, consecutive xStart pulses are exactly N cycles apart when syncTim=N≥1. With syncTim=0 they fall in consecutive cycles.
- R7: A scan has lineCntM1+1 X-line starts, with xIndex counting up from 0. scanDone pulses for one cycle, in the cycle right after the last xStart.
- R8: From the start of a scan until scanDone, no typeStart pulse occurs. Requests that arrive during that time stay pending and are served afterwards.
- R9: syncTim, lineCntM1 and syncEn are taken only while no scan is running. Changing them mid-scan does not alter the spacing or the length of that scan.
- R10: Synchronous active-high rst clears pending requests, stops any scan and drives all outputs to 0 in the following cycle. No start follows until a new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the sync-timer tick |
| rst | input | 1 | Synchronous reset, active high |
| syncPin | input | 1 | Asynchronous mains-derived synchronization input |
| acqReq | input | NUM_TYPES | Per-type acquisition request pulses; bit 0 is the matrix scan |
| syncEn | input | NUM_TYPES | Per-type enable for waiting on a syncPin falling edge |
| syncTim | input | TIM_W | X-line start spacing in cycles; 0 means back to back |
| lineCntM1 | input | LINE_W | Number of X lines per scan, minus one |
| typeStart | output | NUM_TYPES | One-cycle start pulse per acquisition type |
| xStart | output | 1 | One-cycle start pulse for an X line |
| xIndex | output | LINE_W | Index of the X line being started, valid with xStart |
| scanDone | output | 1 | One-cycle pulse after the last X line of a scan |

## Verification
The assertions assume that syncPin is slow compared with the clock. Each level is expected to last several cycles, as a mains waveform does, so that every falling edge is seen exactly once after synchronization. The checks also rely on rst being asserted from time zero. The stimulus keeps every syncPin level for at least four cycles, in both the directed cases and the random phase. It holds rst for several cycles at start-up and at its mid-scan reset, and it varies requests, enables, interval and line count freely. A cycle-level reference model in the bench predicts every output.

// File: rtl/acqtrig_pkg.sv
package acqtrig_pkg;
  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic scanLoad;   // capture configuration, start line 0
    logic lineFire;   // advance to the next X line, reload timer
    logic cntDec;     // count the spacing timer down
  } dpCmd_t;

  localparam int MATRIX_TYPE = 0;
endpackage

// File: rtl/acqtrig_dp.sv
module acqtrig_dp
  import acqtrig_pkg::*;
#(
  parameter int TIM_W = 16,
  parameter int LINE_W = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              syncPin,
  input  logic [TIM_W-1:0]  syncTim,
  input  logic [LINE_W-1:0] lineCntM1,
  input  dpCmd_t            cmd,
  output logic              syncFall,
  output logic              cntZero,
  output logic              atLastLine,
  output logic [LINE_W-1:0] lineIdx
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  // stages [0..SYNC_STAGES-1] synchronize; the top stage holds the previous value
  logic [PIPE_W-1:0] syncPipe;
  logic [TIM_W-1:0]  timLat;
  logic [LINE_W-1:0] lastLat;
  logic [TIM_W-1:0]  cnt;

  function automatic logic [TIM_W-1:0] reloadOf(input logic [TIM_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) syncPipe <= '0;
    else     syncPipe <= {syncPipe[PIPE_W-2:0], syncPin};
  end

  assign syncFall = syncPipe[PIPE_W-1] & ~syncPipe[PIPE_W-2];

  always_ff @(posedge clk) begin
    if (rst) begin
      timLat  <= '0;
      lastLat <= '0;
      cnt     <= '0;
      lineIdx <= '0;
    end else if (cmd.scanLoad) begin
      timLat  <= syncTim;
      lastLat <= lineCntM1;
      cnt     <= reloadOf(syncTim);
      lineIdx <= '0;
    end else if (cmd.lineFire) begin
      cnt     <= reloadOf(timLat);
      lineIdx <= lineIdx + 1'b1;
    end else if (cmd.cntDec && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero    = (cnt == '0);
  assign atLastLine = (lineIdx == lastLat);
endmodule

// File: rtl/acqtrig_ctrl.sv
module acqtrig_ctrl
  import acqtrig_pkg::*;
#(
  parameter int NUM_TYPES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_TYPES-1:0] acqReq,
  input  logic [NUM_TYPES-1:0] syncEn,
  input  logic                 syncFall,
  input  logic                 cntZero,
  input  logic                 atLastLine,
  output dpCmd_t               cmd,
  output logic [NUM_TYPES-1:0] typeStart,
  output logic                 xStart,
  output logic                 scanDone
);
  logic [NUM_TYPES-1:0] pending;
  logic [NUM_TYPES-1:0] cfgEn;
  logic                 scanning;
  logic [NUM_TYPES-1:0] eligible;
  logic [NUM_TYPES-1:0] grant;
  logic                 startScan;
  logic                 lineStep;
  logic                 scanEnd;

  assign eligible = pending & (~cfgEn | {NUM_TYPES{syncFall}});

  // Fixed priority: descending loop so the lowest eligible index wins
  always_comb begin
    grant = '0;
    if (!scanning) begin
      for (int i = NUM_TYPES - 1; i >= 0; i--) begin
        if (eligible[i]) begin
          grant    = '0;
          grant[i] = 1'b1;
        end
      end
    end
  end

  assign startScan = grant[MATRIX_TYPE];
  assign scanEnd   = scanning && atLastLine;
  assign lineStep  = scanning && !atLastLine && cntZero;

  always_comb begin
    cmd.scanLoad = startScan;
    cmd.lineFire = lineStep;
    cmd.cntDec   = scanning && !atLastLine && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pending   <= '0;
      cfgEn     <= '0;
      scanning  <= 1'b0;
      typeStart <= '0;
      xStart    <= 1'b0;
      scanDone  <= 1'b0;
    end else begin
      pending   <= (pending & ~grant) | (acqReq & ~pending);
      typeStart <= grant;
      xStart    <= startScan | lineStep;
      scanDone  <= scanEnd;
      if (!scanning) cfgEn <= syncEn;
      if (startScan)    scanning <= 1'b1;
      else if (scanEnd) scanning <= 1'b0;
    end
  end
endmodule

// File: rtl/mains_sync_trigger.sv
module mains_sync_trigger
  import acqtrig_pkg::*;
#(
  parameter int NUM_TYPES = 4,
  parameter int TIM_W = 16,
  parameter int LINE_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 syncPin,
  input  logic [NUM_TYPES-1:0] acqReq,
  input  logic [NUM_TYPES-1:0] syncEn,
  input  logic [TIM_W-1:0]     syncTim,
  input  logic [LINE_W-1:0]    lineCntM1,
  output logic [NUM_TYPES-1:0] typeStart,
  output logic                 xStart,
  output logic [LINE_W-1:0]    xIndex,
  output logic                 scanDone
);
  dpCmd_t cmd;
  logic   syncFall;
  logic   cntZero;
  logic   atLastLine;

  acqtrig_ctrl #(.NUM_TYPES(NUM_TYPES)) uCtrl (
    .clk(clk), .rst(rst), .acqReq(acqReq), .syncEn(syncEn),
    .syncFall(syncFall), .cntZero(cntZero), .atLastLine(atLastLine),
    .cmd(cmd), .typeStart(typeStart), .xStart(xStart), .scanDone(scanDone)
  );

  acqtrig_dp #(.TIM_W(TIM_W), .LINE_W(LINE_W)) uDp (
    .clk(clk), .rst(rst), .syncPin(syncPin), .syncTim(syncTim),
    .lineCntM1(lineCntM1), .cmd(cmd), .syncFall(syncFall),
    .cntZero(cntZero), .atLastLine(atLastLine), .lineIdx(xIndex)
  );
endmodule

// File: rtl/mains_sync_trigger_chk.sv
module mains_sync_trigger_chk #(
  parameter int NUM_TYPES = 4,
  parameter int LINE_W = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_TYPES-1:0] typeStart,
  input logic                 xStart,
  input logic [LINE_W-1:0]    xIndex,
  input logic                 scanDone
);
  // R4
  one_start_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(typeStart));

  // R3
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (rst)
    (typeStart != '0) |=> ((typeStart & $past(typeStart)) == '0));

  // R5
  scan_first_line_chk: assert property (@(posedge clk) disable iff (rst)
    typeStart[0] |-> (xStart && xIndex == '0));

  // R8
  no_other_start_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    ((typeStart >> 1) != '0) |-> !xStart);

  // R7
  done_after_line_chk: assert property (@(posedge clk) disable iff (rst)
    scanDone |-> ($past(xStart) && !xStart));

  // R10
  quiet_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (typeStart == '0 && !xStart && !scanDone));
endmodule

bind mains_sync_trigger mains_sync_trigger_chk #(
  .NUM_TYPES(NUM_TYPES), .LINE_W(LINE_W)
) uChk (
  .clk(clk), .rst(rst), .typeStart(typeStart), .xStart(xStart),
  .xIndex(xIndex), .scanDone(scanDone)
);

// File: tb/tb_mains_sync_trigger.sv
module tb_mains_sync_trigger;
  localparam int NT = 4;
  localparam int TW = 16;
  localparam int LW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          syncPin = 1'b1;
  logic [NT-1:0] acqReq = '0;
  logic [NT-1:0] syncEn = '0;
  logic [TW-1:0] syncTim = '0;
  logic [LW-1:0] lineCntM1 = '0;
  logic [NT-1:0] typeStart;
  logic          xStart;
  logic [LW-1:0] xIndex;
  logic          scanDone;

  always #2 clk = ~clk;

  mains_sync_trigger #(.NUM_TYPES(NT), .TIM_W(TW), .LINE_W(LW)) dut (
    .clk(clk), .rst(rst), .syncPin(syncPin), .acqReq(acqReq),
    .syncEn(syncEn), .syncTim(syncTim), .lineCntM1(lineCntM1),
    .typeStart(typeStart), .xStart(xStart), .xIndex(xIndex),
    .scanDone(scanDone)
  );

  int    errs = 0;
  int    checks = 0;
  string tag = "R10";
  bit    finished = 0;

  // reference model state
  logic [2:0]    mSync;
  logic [NT-1:0] mPend, mEn, eType;
  bit            mScan, eX, eDone;
  int            eIdx, mLast, mTim;
  int            cyc = 0;
  int            mNext;

  int xLog[$];
  int dLog[$];
  int tLog[$];
  int tIdx[$];

  function automatic int gapOf(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)",
               req, what, act, exp, cyc);
    end
  endtask

  task automatic modelStep();
    bit fall;
    bit wasScan;
    logic [NT-1:0] req;
    cyc++;
    if (rst) begin
      mSync = '0; mPend = '0; mEn = '0; mScan = 0;
      eType = '0; eX = 0; eDone = 0; eIdx = 0;
    end else begin
      fall    = mSync[2] & ~mSync[1];
      wasScan = mScan;
      req     = acqReq & ~mPend;
      eType = '0; eX = 0; eDone = 0;
      if (!wasScan) begin
        for (int i = 0; i < NT; i++) begin
          if (eType == '0 && mPend[i] && (!mEn[i] || fall)) begin
            eType[i] = 1'b1;
            mPend[i] = 1'b0;
            if (i == 0) begin
              mScan = 1; eX = 1; eIdx = 0;
              mTim = int'(syncTim); mLast = int'(lineCntM1);
              mNext = cyc + gapOf(mTim);
            end
          end
        end
        mEn = syncEn;
      end else if (eIdx == mLast) begin
        eDone = 1; mScan = 0;
      end else if (cyc == mNext) begin
        eX = 1; eIdx++;
        mNext = cyc + gapOf(mTim);
      end
      mPend = mPend | req;
      mSync = {mSync[1:0], syncPin};
    end
  endtask

  task automatic step();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    chk(typeStart === eType, tag, "typeStart", int'(typeStart), int'(eType));
    chk(xStart === eX, tag, "xStart", int'(xStart), int'(eX));
    chk(scanDone === eDone, tag, "scanDone", int'(scanDone), int'(eDone));
    if (eX) chk(int'(xIndex) == eIdx, tag, "xIndex", int'(xIndex), eIdx);
    if (xStart) xLog.push_back(cyc);
    if (scanDone) dLog.push_back(cyc);
    for (int i = 0; i < NT; i++)
      if (typeStart[i]) begin tLog.push_back(cyc); tIdx.push_back(i); end
  endtask

  task automatic steps(input int n);
    for (int k = 0; k < n; k++) step();
  endtask

  task automatic clearLogs();
    xLog.delete(); dLog.delete(); tLog.delete(); tIdx.delete();
  endtask

  task automatic pulseReq(input logic [NT-1:0] r);
    acqReq = r; step(); acqReq = '0;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual=expired expected=finished");
    report();
  end

  initial begin
    int hold;
    @(negedge clk);
    steps(4);
    rst = 0;
    // R10: reset state
    tag = "R10";
    step();
    chk(typeStart == 0 && !xStart && !scanDone, "R10", "outputs after reset",
        int'({typeStart, xStart, scanDone}), 0);
    steps(3);

    // R2: unsynchronized type starts two cycles after request
    tag = "R2"; syncEn = '0; step(); clearLogs();
    pulseReq(4'b0100);
    step();
    chk(typeStart == 4'b0100, "R2", "start two cycles after request",
        int'(typeStart), 4);
    steps(3);

    // R1: synchronized type waits for a falling edge, not a rising one
    tag = "R1"; syncPin = 1; syncEn = 4'b0010; steps(6); clearLogs();
    pulseReq(4'b0010); steps(5);
    chk(tLog.size() == 0, "R1", "no start without edge", tLog.size(), 0);
    syncPin = 0; step(); step();
    chk(typeStart == 0, "R1", "no start two edges after fall", int'(typeStart), 0);
    step();
    chk(typeStart == 4'b0010, "R1", "start on third edge after fall",
        int'(typeStart), 2);
    steps(4); clearLogs();
    pulseReq(4'b0010); syncPin = 1; steps(8);
    chk(tLog.size() == 0, "R1", "rising edge starts nothing", tLog.size(), 0);

    // R3: duplicate request while pending yields a single start
    tag = "R3"; clearLogs();
    pulseReq(4'b0010); step(); pulseReq(4'b0010);
    syncPin = 0; steps(6); syncPin = 1; steps(6); syncPin = 0; steps(6);
    chk(tLog.size() == 1, "R3", "single pulse per request", tLog.size(), 1);

    // R4: priority among types sharing an edge
    tag = "R4"; syncPin = 1; syncEn = 4'b1110; steps(5); clearLogs();
    pulseReq(4'b1110); steps(3);
    syncPin = 0; steps(6);
    chk(tLog.size() == 1 && tIdx[0] == 1, "R4", "lowest index first",
        tIdx.size() > 0 ? tIdx[0] : -1, 1);
    syncPin = 1; steps(5); syncPin = 0; steps(6);
    chk(tIdx.size() == 2 && tIdx[1] == 2, "R4", "next type on later edge",
        tIdx.size() > 1 ? tIdx[1] : -1, 2);
    syncPin = 1; steps(5); syncPin = 0; steps(6);

    // R5 R6 R7: scan with spacing 5 and four lines
    tag = "R6"; syncEn = '0; syncTim = 5; lineCntM1 = 3; steps(2); clearLogs();
    pulseReq(4'b0001); steps(30);
    chk(xLog.size() == 4, "R7", "line count", xLog.size(), 4);
    chk(tLog.size() == 1 && xLog.size() > 0 && tLog[0] == xLog[0], "R5",
        "first line with type start", xLog.size() > 0 ? xLog[0] : -1,
        tLog.size() > 0 ? tLog[0] : -1);
    for (int k = 1; k < xLog.size(); k++)
      chk(xLog[k] - xLog[k-1] == 5, "R6", "spacing N=5", xLog[k] - xLog[k-1], 5);
    chk(dLog.size() == 1 && xLog.size() == 4 && dLog[0] == xLog[3] + 1, "R7",
        "done after last line", dLog.size() > 0 ? dLog[0] : -1,
        xLog.size() == 4 ? xLog[3] + 1 : -1);

    // R6: back to back with zero interval
    syncTim = 0; lineCntM1 = 2; steps(2); clearLogs();
    pulseReq(4'b0001); steps(8);
    chk(xLog.size() == 3 && xLog[2] - xLog[0] == 2, "R6", "back-to-back lines",
        xLog.size() == 3 ? xLog[2] - xLog[0] : -1, 2);

    // R8: other request during a scan waits for scanDone
    tag = "R8"; syncTim = 4; lineCntM1 = 2; steps(2); clearLogs();
    pulseReq(4'b0001); steps(2); pulseReq(4'b1000); steps(20);
    chk(tLog.size() == 2 && dLog.size() == 1 && tLog[1] > dLog[0], "R8",
        "held until scan done", tLog.size() == 2 ? tLog[1] : -1,
        dLog.size() > 0 ? dLog[0] + 1 : -1);

    // R9: configuration changes mid-scan have no effect on that scan
    tag = "R9"; syncTim = 3; lineCntM1 = 2; steps(2); clearLogs();
    pulseReq(4'b0001); step(); syncTim = 9; lineCntM1 = 0; syncEn = 4'b1111;
    steps(15);
    chk(xLog.size() == 3, "R9", "line count kept", xLog.size(), 3);
    chk(xLog.size() == 3 && xLog[1] - xLog[0] == 3, "R9", "spacing kept",
        xLog.size() == 3 ? xLog[1] - xLog[0] : -1, 3);
    syncEn = '0; syncTim = 0; lineCntM1 = 0; steps(3);

    // R10: reset mid-scan
    tag = "R10"; syncTim = 6; lineCntM1 = 5; steps(2);
    pulseReq(4'b0001); steps(4); rst = 1; steps(3); rst = 0; clearLogs();
    steps(40);
    chk(xLog.size() == 0 && tLog.size() == 0, "R10", "scan stopped by reset",
        xLog.size() + tLog.size(), 0);

    // random phase: model comparison every cycle
    tag = "R4";
    void'($urandom(32'h5eed_1234));
    hold = 6;
    for (int n = 0; n < 4000; n++) begin
      if (hold == 0) begin syncPin = ~syncPin; hold = 4 + ($urandom % 27); end
      else hold--;
      acqReq = (($urandom % 5) == 0) ? NT'($urandom) : '0;
      if (($urandom % 40) == 0) syncEn = NT'($urandom);
      if (($urandom % 60) == 0) syncTim = TW'($urandom % 7);
      if (($urandom % 60) == 0) lineCntM1 = LW'($urandom % 6);
      tag = (n % 2 == 0) ? "R6" : "R4";
      step();
    end
    acqReq = '0;
    steps(5);
    report();
  end
endmodule